// File: doc/BRIEF.md
# Bridge Address Translation Windows

This block holds the address translation tables of a bus bridge and answers translation lookups in both directions. Four outbound windows each map a range of CPU addresses onto the bus. Three inbound windows each map a range of bus addresses onto local memory. Software programs each window through a 32-bit register port. For each window it sets a translation page, a base page and an attribute word. The attribute word carries an enable bit and a power-of-two size code. The same register space also holds one spare timer word.

There are two lookup ports, one outbound and one inbound. Each port takes a 64-bit address every cycle. One cycle later it returns a hit flag, the translated address and the number of the window that matched. When windows overlap, the lowest-numbered enabled window is chosen. The block generates no bus traffic. It only computes where an access belongs.

Top module: `xlat_window_unit`

## Requirements
- R1: During and after a synchronous reset, every register reads as zero and both lookup ports report a miss with a zero address and a zero window number.
- R2: Register map, with offsets as byte offsets in a 4 KB space. Outbound window n (n = 1..4) starts at 0xC00 + n*0x20 and has these words: translation page at +0x0, extended translation at +0x4, base page at +0x8 and attribute at +0x10. Inbound window m (m = 0..2) starts at 0xDA0 + m*0x20 and has these words: translation page at +0x0, base page at +0x8, extended base at +0xC and attribute at +0x10. A read strobe returns the last value written on reg_rdata one cycle later. Without a strobe, reg_rdata is zero.
- R3: The word at offset 0xE20 is plain read/write storage and has no effect on any lookup.
- R4: Reads of any other offset return zero, including unused words inside a window. Writes to such offsets change no register and no lookup result.
- R5: The register port is big-endian. Port bits [7:0] carry register bits [31:24] and port bits [31:24] carry register bits [7:0], in both directions.
- R6: A window takes part in lookups only while attribute bit 31 is set. A disabled window never hits.
- R7: With base = base page << 12 and size = 2 << attribute[5:0] bytes, a window hits exactly when base <= addr < base + size. The comparison is made without losing the carry for the size codes near 63.
- R8: On a hit, the translated address is (translation page << 12) + (addr - base) modulo 2^64. The outbound window number is reported as 1..4 and the inbound window number as 0..2.
- R9: When several enabled windows hit, the one with the lowest window number is reported.
- R10: Results appear on the cycle after the address is presented. A register write affects every lookup presented after the write cycle. A miss reports a zero address and window number 0.
- R11: The extended translation and extended base words are stored and read back, but they do not change any lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data, big-endian lanes |
| reg_rdata | output | 32 | Read data one cycle after the strobe, big-endian lanes |
| ob_addr | input | 64 | Outbound lookup address (CPU side) |
| ob_hit | output | 1 | Outbound lookup hit |
| ob_xaddr | output | 64 | Outbound translated bus address |
| ob_win | output | 3 | Outbound matching window, 1..4 |
| ib_addr | input | 64 | Inbound lookup address (bus side) |
| ib_hit | output | 1 | Inbound lookup hit |
| ib_xaddr | output | 64 | Inbound translated local address |
| ib_win | output | 2 | Inbound matching window, 0..2 |

## Verification
The bench sweeps every window across its first byte, its last byte and the bytes just outside it.
- A design that used an inclusive upper bound, or dropped the carry for size codes near 63, would hit one byte too far or miss the whole space.
- Overlapping windows are enabled and disabled in turn. A reversed priority would report the higher-numbered window.
- Raw writes through the port expose byte-lane order, because a swapped base page moves the window.
- Writes to unused words, to the gaps between groups and to the extended words are followed by readback and lookups. A loose decode would overwrite a neighbouring register or shift a translation.

// File: rtl/xlw_pkg.sv
package xlw_pkg;
  localparam int REG_W      = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int SZ_W       = 6;
  localparam int EN_BIT     = 31;

  typedef struct packed {
    logic [REG_W-1:0] xpage;
    logic [REG_W-1:0] aux;
    logic [REG_W-1:0] bpage;
    logic [REG_W-1:0] attr;
  } win_regs_t;

  function automatic logic [REG_W-1:0] swap_bytes(input logic [REG_W-1:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/xlw_regfile.sv
module xlw_regfile
  import xlw_pkg::*;
#(
  parameter int NUM_OB     = 4,
  parameter int NUM_IB     = 3,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [11:0]                  addr,
  input  logic [REG_W-1:0]             wdata,
  output logic [REG_W-1:0]             rdata,
  output logic [NUM_OB-1:0]            ob_en,
  output logic [NUM_OB-1:0][SZ_W-1:0]  ob_sz,
  output logic [NUM_OB-1:0][REG_W-1:0] ob_xpage,
  output logic [NUM_OB-1:0][REG_W-1:0] ob_bpage,
  output logic [NUM_IB-1:0]            ib_en,
  output logic [NUM_IB-1:0][SZ_W-1:0]  ib_sz,
  output logic [NUM_IB-1:0][REG_W-1:0] ib_xpage,
  output logic [NUM_IB-1:0][REG_W-1:0] ib_bpage
);
  localparam int          IB_FIRST = 4 - NUM_IB;
  localparam logic [11:0] TMR_OFF  = 12'hE20;

  win_regs_t        ob_q [NUM_OB];
  win_regs_t        ib_q [NUM_IB];
  logic [REG_W-1:0] tmr_q;
  logic [REG_W-1:0] rd_word, rdata_q, wval;

  logic       ob_sel, ib_sel, tmr_sel;
  logic [2:0] ob_k;
  logic [1:0] ib_k;
  logic [4:0] sub;

  assign sub     = addr[4:0];
  assign ob_sel  = (addr[11:8] == 4'hC) && (addr[7:5] != 3'd0) && (addr[7:5] <= 3'(NUM_OB));
  assign ob_k    = addr[7:5] - 3'd1;
  assign ib_sel  = (addr[11:7] == 5'h1B) && (addr[6:5] >= 2'(IB_FIRST));
  assign ib_k    = addr[6:5] - 2'(IB_FIRST);
  assign tmr_sel = (addr == TMR_OFF);

  generate
    if (BIG_ENDIAN) begin : g_be
      assign wval  = swap_bytes(wdata);
      assign rdata = swap_bytes(rdata_q);
    end else begin : g_le
      assign wval  = wdata;
      assign rdata = rdata_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_OB; k++) ob_q[k] <= '0;
      for (int k = 0; k < NUM_IB; k++) ib_q[k] <= '0;
      tmr_q <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NUM_OB; k++) begin
        if (ob_sel && ob_k == 3'(k)) begin
          case (sub)
            5'h00:   ob_q[k].xpage <= wval;
            5'h04:   ob_q[k].aux   <= wval;
            5'h08:   ob_q[k].bpage <= wval;
            5'h10:   ob_q[k].attr  <= wval;
            default: ;
          endcase
        end
      end
      for (int k = 0; k < NUM_IB; k++) begin
        if (ib_sel && ib_k == 2'(k)) begin
          case (sub)
            5'h00:   ib_q[k].xpage <= wval;
            5'h08:   ib_q[k].bpage <= wval;
            5'h0C:   ib_q[k].aux   <= wval;
            5'h10:   ib_q[k].attr  <= wval;
            default: ;
          endcase
        end
      end
      if (tmr_sel) tmr_q <= wval;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NUM_OB; k++) begin
      if (ob_sel && ob_k == 3'(k)) begin
        case (sub)
          5'h00:   rd_word = ob_q[k].xpage;
          5'h04:   rd_word = ob_q[k].aux;
          5'h08:   rd_word = ob_q[k].bpage;
          5'h10:   rd_word = ob_q[k].attr;
          default: ;
        endcase
      end
    end
    for (int k = 0; k < NUM_IB; k++) begin
      if (ib_sel && ib_k == 2'(k)) begin
        case (sub)
          5'h00:   rd_word = ib_q[k].xpage;
          5'h08:   rd_word = ib_q[k].bpage;
          5'h0C:   rd_word = ib_q[k].aux;
          5'h10:   rd_word = ib_q[k].attr;
          default: ;
        endcase
      end
    end
    if (tmr_sel) rd_word = tmr_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_word;
    else            rdata_q <= '0;
  end

  generate
    for (genvar k = 0; k < NUM_OB; k++) begin : g_ob_out
      assign ob_en[k]    = ob_q[k].attr[EN_BIT];
      assign ob_sz[k]    = ob_q[k].attr[SZ_W-1:0];
      assign ob_xpage[k] = ob_q[k].xpage;
      assign ob_bpage[k] = ob_q[k].bpage;
    end
    for (genvar k = 0; k < NUM_IB; k++) begin : g_ib_out
      assign ib_en[k]    = ib_q[k].attr[EN_BIT];
      assign ib_sz[k]    = ib_q[k].attr[SZ_W-1:0];
      assign ib_xpage[k] = ib_q[k].xpage;
      assign ib_bpage[k] = ib_q[k].bpage;
    end
  endgenerate
endmodule

// File: rtl/xlw_win_match.sv
module xlw_win_match
  import xlw_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic             en,
  input  logic [SZ_W-1:0]  sz,
  input  logic [REG_W-1:0] xpage,
  input  logic [REG_W-1:0] bpage,
  input  logic [AW-1:0]    addr,
  output logic             hit,
  output logic [AW-1:0]    xaddr
);
  logic [AW-1:0] base, delta;
  logic [AW:0]   size;

  assign base  = AW'({bpage, {PAGE_SHIFT{1'b0}}});
  assign delta = addr - base;
  assign size  = (AW+1)'(2) << sz;
  assign hit   = en && (addr >= base) && ({1'b0, delta} < size);
  assign xaddr = AW'({xpage, {PAGE_SHIFT{1'b0}}}) + delta;
endmodule

// File: rtl/xlw_pick.sv
module xlw_pick #(
  parameter int N   = 4,
  parameter int AW  = 64,
  parameter int IW  = 3,
  parameter int OFS = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          hit,
  input  logic [N-1:0][AW-1:0]  xa,
  output logic                  hit_q,
  output logic [AW-1:0]         xa_q,
  output logic [IW-1:0]         idx_q
);
  logic          s_hit;
  logic [AW-1:0] s_xa;
  logic [IW-1:0] s_idx;

  always_comb begin
    s_hit = 1'b0;
    s_xa  = '0;
    s_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hit[k]) begin
        s_hit = 1'b1;
        s_xa  = xa[k];
        s_idx = IW'(k + OFS);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      xa_q  <= '0;
      idx_q <= '0;
    end else begin
      hit_q <= s_hit;
      xa_q  <= s_xa;
      idx_q <= s_idx;
    end
  end
endmodule

// File: rtl/xlat_window_unit.sv
module xlat_window_unit
  import xlw_pkg::*;
#(
  parameter int  NUM_OB     = 4,
  parameter int  NUM_IB     = 3,
  parameter int  AW         = 64,
  parameter bit  BIG_ENDIAN = 1'b1,
  localparam int OB_IW      = $clog2(NUM_OB + 1),
  localparam int IB_IW      = $clog2(NUM_IB + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr_en,
  input  logic             reg_rd_en,
  input  logic [11:0]      reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [AW-1:0]    ob_addr,
  output logic             ob_hit,
  output logic [AW-1:0]    ob_xaddr,
  output logic [OB_IW-1:0] ob_win,
  input  logic [AW-1:0]    ib_addr,
  output logic             ib_hit,
  output logic [AW-1:0]    ib_xaddr,
  output logic [IB_IW-1:0] ib_win
);
  logic [NUM_OB-1:0]            ob_en, ob_m_hit;
  logic [NUM_OB-1:0][SZ_W-1:0]  ob_sz;
  logic [NUM_OB-1:0][REG_W-1:0] ob_xpage, ob_bpage;
  logic [NUM_OB-1:0][AW-1:0]    ob_m_xa;
  logic [NUM_IB-1:0]            ib_en, ib_m_hit;
  logic [NUM_IB-1:0][SZ_W-1:0]  ib_sz;
  logic [NUM_IB-1:0][REG_W-1:0] ib_xpage, ib_bpage;
  logic [NUM_IB-1:0][AW-1:0]    ib_m_xa;

  xlw_regfile #(.NUM_OB(NUM_OB), .NUM_IB(NUM_IB), .BIG_ENDIAN(BIG_ENDIAN)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .ob_en(ob_en), .ob_sz(ob_sz), .ob_xpage(ob_xpage), .ob_bpage(ob_bpage),
    .ib_en(ib_en), .ib_sz(ib_sz), .ib_xpage(ib_xpage), .ib_bpage(ib_bpage)
  );

  generate
    for (genvar k = 0; k < NUM_OB; k++) begin : g_ob
      xlw_win_match #(.AW(AW)) u_m (
        .en(ob_en[k]), .sz(ob_sz[k]), .xpage(ob_xpage[k]), .bpage(ob_bpage[k]),
        .addr(ob_addr), .hit(ob_m_hit[k]), .xaddr(ob_m_xa[k])
      );
    end
    for (genvar k = 0; k < NUM_IB; k++) begin : g_ib
      xlw_win_match #(.AW(AW)) u_m (
        .en(ib_en[k]), .sz(ib_sz[k]), .xpage(ib_xpage[k]), .bpage(ib_bpage[k]),
        .addr(ib_addr), .hit(ib_m_hit[k]), .xaddr(ib_m_xa[k])
      );
    end
  endgenerate

  xlw_pick #(.N(NUM_OB), .AW(AW), .IW(OB_IW), .OFS(1)) u_ob_pick (
    .clk(clk), .rst(rst), .hit(ob_m_hit), .xa(ob_m_xa),
    .hit_q(ob_hit), .xa_q(ob_xaddr), .idx_q(ob_win)
  );

  xlw_pick #(.N(NUM_IB), .AW(AW), .IW(IB_IW), .OFS(0)) u_ib_pick (
    .clk(clk), .rst(rst), .hit(ib_m_hit), .xa(ib_m_xa),
    .hit_q(ib_hit), .xa_q(ib_xaddr), .idx_q(ib_win)
  );
endmodule

// File: rtl/xlw_checker.sv
module xlw_checker #(
  parameter int NUM_OB = 4,
  parameter int NUM_IB = 3,
  parameter int AW     = 64,
  parameter int OB_IW  = 3,
  parameter int IB_IW  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr_en,
  input logic             reg_rd_en,
  input logic [11:0]      reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             ob_hit,
  input logic [AW-1:0]    ob_xaddr,
  input logic [OB_IW-1:0] ob_win,
  input logic             ib_hit,
  input logic [AW-1:0]    ib_xaddr,
  input logic [IB_IW-1:0] ib_win
);
  localparam logic [11:0] TMR = 12'hE20;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (!ob_hit && !ib_hit && reg_rdata == '0)); // R1

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_en |=> reg_rdata == '0); // R2

  AST_TIMER_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && !reg_wr_en && reg_addr == TMR && $past(reg_wr_en && reg_addr == TMR))
    |=> reg_rdata == $past(reg_wdata, 2)); // R3

  AST_LOW_SPACE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_addr < 12'hC20) |=> reg_rdata == '0); // R4

  AST_OB_WIN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ob_hit |-> (ob_win >= OB_IW'(1) && ob_win <= OB_IW'(NUM_OB))); // R8

  AST_IB_WIN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ib_hit |-> ib_win < IB_IW'(NUM_IB)); // R8

  AST_OB_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !ob_hit |-> (ob_xaddr == '0 && ob_win == '0)); // R10

  AST_IB_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !ib_hit |-> (ib_xaddr == '0 && ib_win == '0)); // R10
endmodule

bind xlat_window_unit xlw_checker #(
  .NUM_OB(NUM_OB), .NUM_IB(NUM_IB), .AW(AW), .OB_IW(OB_IW), .IB_IW(IB_IW)
) u_xlw_chk (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .ob_hit(ob_hit), .ob_xaddr(ob_xaddr), .ob_win(ob_win),
  .ib_hit(ib_hit), .ib_xaddr(ib_xaddr), .ib_win(ib_win)
);

// File: tb/xlat_window_unit_tb_top.sv
module xlat_window_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [63:0] ob_addr = '0, ob_xaddr, ib_addr = '0, ib_xaddr;
  logic        ob_hit, ib_hit;
  logic [2:0]  ob_win;
  logic [1:0]  ib_win;

  always #10 clk = ~clk;

  xlat_window_unit dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ob_addr(ob_addr), .ob_hit(ob_hit), .ob_xaddr(ob_xaddr), .ob_win(ob_win),
    .ib_addr(ib_addr), .ib_hit(ib_hit), .ib_xaddr(ib_xaddr), .ib_win(ib_win)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] mo_x [1:4], mo_b [1:4], mo_a [1:4];
  logic [31:0] mi_x [0:2], mi_b [0:2], mi_a [0:2];
  logic [63:0] lcg = 64'h1234_5678_9ABC_DEF1;

  function automatic logic [31:0] bsw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
  function automatic logic [11:0] ob_off(input int n); return 12'(12'hC00 + n * 32); endfunction
  function automatic logic [11:0] ib_off(input int m); return 12'(12'hDA0 + m * 32); endfunction

  function automatic bit win_hit(input logic [31:0] b, input logic [31:0] a, input logic [63:0] addr);
    logic [63:0] base = {20'h0, b, 12'h0};
    logic [64:0] size = 65'd2 << a[5:0];
    return a[31] && (addr >= base) && ({1'b0, addr - base} < size);
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = bsw(v);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    v = bsw(reg_rdata);
  endtask

  task automatic set_ob(input int n, input logic [31:0] x, input logic [31:0] b, input logic [31:0] a);
    wr(ob_off(n) + 12'h0, x); wr(ob_off(n) + 12'h8, b); wr(ob_off(n) + 12'h10, a);
    mo_x[n] = x; mo_b[n] = b; mo_a[n] = a;
  endtask

  task automatic set_ib(input int m, input logic [31:0] x, input logic [31:0] b, input logic [31:0] a);
    wr(ib_off(m) + 12'h0, x); wr(ib_off(m) + 12'h8, b); wr(ib_off(m) + 12'h10, a);
    mi_x[m] = x; mi_b[m] = b; mi_a[m] = a;
  endtask

  // R7 R8 R9 R10: one-cycle lookup against the arithmetic model
  task automatic look_ob(input logic [63:0] a, input string req);
    logic        eh = 0;
    logic [63:0] ex = 0;
    logic [2:0]  ew = 0;
    @(negedge clk); ob_addr = a;
    @(negedge clk);
    for (int n = 4; n >= 1; n--)
      if (win_hit(mo_b[n], mo_a[n], a)) begin
        eh = 1; ew = 3'(n); ex = {20'h0, mo_x[n], 12'h0} + (a - {20'h0, mo_b[n], 12'h0});
      end
    chk(req, {ob_hit, ob_win, ob_xaddr}, {eh, ew, ex});
  endtask

  task automatic look_ib(input logic [63:0] a, input string req);
    logic        eh = 0;
    logic [63:0] ex = 0;
    logic [1:0]  ew = 0;
    @(negedge clk); ib_addr = a;
    @(negedge clk);
    for (int m = 2; m >= 0; m--)
      if (win_hit(mi_b[m], mi_a[m], a)) begin
        eh = 1; ew = 2'(m); ex = {20'h0, mi_x[m], 12'h0} + (a - {20'h0, mi_b[m], 12'h0});
      end
    chk(req, {ib_hit, ib_win, ib_xaddr}, {eh, ew, ex});
  endtask

  task automatic edges(input logic [31:0] b, input logic [31:0] a, output logic [63:0] e [6]);
    logic [63:0] base = {20'h0, b, 12'h0};
    logic [64:0] size = 65'd2 << a[5:0];
    e[0] = base - 1; e[1] = base; e[2] = base + 1;
    e[3] = base + 64'(size >> 1); e[4] = base + 64'(size) - 1; e[5] = base + 64'(size);
  endtask

  task automatic sweep_ob(input string req);
    logic [63:0] e [6];
    for (int n = 1; n <= 4; n++) begin
      edges(mo_b[n], mo_a[n], e);
      for (int i = 0; i < 6; i++) look_ob(e[i], req);
    end
    for (int i = 0; i < 12; i++) begin
      lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
      look_ob({40'h0, lcg[47:24]}, req);
    end
  endtask

  task automatic sweep_ib(input string req);
    logic [63:0] e [6];
    for (int m = 0; m <= 2; m++) begin
      edges(mi_b[m], mi_a[m], e);
      for (int i = 0; i < 6; i++) look_ib(e[i], req);
    end
    for (int i = 0; i < 12; i++) begin
      lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
      look_ib({40'h0, lcg[47:24]}, req);
    end
  endtask

  function automatic logic [31:0] pat(input int g, input int s);
    return {8'h5A, 8'(g), 8'(s), 8'h3C};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [11:0] junk [10];
    int          subs [4];
    for (int n = 1; n <= 4; n++) begin mo_x[n] = 0; mo_b[n] = 0; mo_a[n] = 0; end
    for (int m = 0; m <= 2; m++) begin mi_x[m] = 0; mi_b[m] = 0; mi_a[m] = 0; end

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 rdata", {96'h0, reg_rdata}, 128'h0);
    chk("R1 ob", {ob_hit, ob_win, ob_xaddr}, 128'h0);
    chk("R1 ib", {ib_hit, ib_win, ib_xaddr}, 128'h0);
    rd(ob_off(1) + 12'h10, v); chk("R1 ob attr", {96'h0, v}, 128'h0);
    rd(ib_off(2) + 12'h8, v);  chk("R1 ib base", {96'h0, v}, 128'h0);
    rd(12'hE20, v);            chk("R1 timer", {96'h0, v}, 128'h0);
    look_ob(64'h0, "R1 ob lookup");
    look_ib(64'h0, "R1 ib lookup");

    // R2: register map readback (bit 31 clear, windows stay off)
    subs = '{0, 4, 8, 16};
    for (int n = 1; n <= 4; n++) for (int s = 0; s < 4; s++) wr(ob_off(n) + 12'(subs[s]), pat(n, subs[s]));
    subs = '{0, 8, 12, 16};
    for (int m = 0; m <= 2; m++) for (int s = 0; s < 4; s++) wr(ib_off(m) + 12'(subs[s]), pat(8 + m, subs[s]));
    subs = '{0, 4, 8, 16};
    for (int n = 1; n <= 4; n++) for (int s = 0; s < 4; s++) begin
      rd(ob_off(n) + 12'(subs[s]), v); chk("R2 ob readback", {96'h0, v}, {96'h0, pat(n, subs[s])});
    end
    subs = '{0, 8, 12, 16};
    for (int m = 0; m <= 2; m++) for (int s = 0; s < 4; s++) begin
      rd(ib_off(m) + 12'(subs[s]), v); chk("R2 ib readback", {96'h0, v}, {96'h0, pat(8 + m, subs[s])});
    end
    @(negedge clk);
    chk("R2 idle rdata", {96'h0, reg_rdata}, 128'h0);

    // R3: timer storage
    wr(12'hE20, 32'hDEAD_BEEF);
    rd(12'hE20, v); chk("R3 timer", {96'h0, v}, {96'h0, 32'hDEAD_BEEF});

    // R4: unused and unmapped offsets
    junk = '{12'h000, 12'h004, 12'hC00, 12'hC2C, 12'hC34, 12'hCA0, 12'hD80, 12'hDA4, 12'hE24, 12'hFFC};
    for (int i = 0; i < 10; i++) wr(junk[i], 32'hFFFF_FFFF);
    for (int i = 0; i < 10; i++) begin
      rd(junk[i], v); chk("R4 unused reads zero", {96'h0, v}, 128'h0);
    end
    rd(ob_off(1) + 12'h8, v);  chk("R4 ob1 base intact", {96'h0, v}, {96'h0, pat(1, 8)});
    rd(ob_off(1) + 12'h10, v); chk("R4 ob1 attr intact", {96'h0, v}, {96'h0, pat(1, 16)});
    rd(ib_off(0) + 12'h0, v);  chk("R4 ib0 xlat intact", {96'h0, v}, {96'h0, pat(8, 0)});
    rd(12'hE20, v);            chk("R4 timer intact", {96'h0, v}, {96'h0, 32'hDEAD_BEEF});
    look_ob(64'h0001_0000, "R4 no window enabled");

    // R6: disabled windows never hit
    set_ob(1, 32'h500, 32'h10, 32'h0000_000C);
    set_ob(2, 32'h100, 32'h20, 32'h7FFF_FF0B);
    set_ob(3, 32'h700, 32'h0, 32'h0000_003F);
    set_ob(4, 32'h0, 32'h30, 32'h0000_0000);
    sweep_ob("R6 disabled");

    // R5: raw big-endian lanes move the base page
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = ob_off(1) + 12'h8; reg_wdata = 32'h0000_0100;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_rd_en = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0;
    chk("R5 raw lanes", {96'h0, reg_rdata}, {96'h0, 32'h0000_0100});
    mo_b[1] = 32'h0001_0000;
    wr(ob_off(1) + 12'h10, 32'h8000_000C); mo_a[1] = 32'h8000_000C;
    look_ob(64'h1000_0000, "R5 base from swapped lanes");
    look_ob(64'h0001_0000, "R5 unswapped base misses");

    // R7 R8 R10: enabled windows of several sizes
    set_ob(1, 32'h500, 32'h10, 32'h8000_000C);
    set_ob(2, 32'h100, 32'h20, 32'h8000_000B);
    set_ob(4, 32'hFFFF_FFFF, 32'h30, 32'h8000_0000);
    sweep_ob("R7 R8 bounds and translation");

    // R9: overlap priority
    set_ob(3, 32'h700, 32'h11, 32'h8000_000D);
    sweep_ob("R9 lowest wins");
    look_ob(64'h0001_1800, "R9 ob1 over ob3");
    wr(ob_off(1) + 12'h10, 32'h0000_000C); mo_a[1] = 32'h0000_000C;
    look_ob(64'h0001_1800, "R10 write seen by next lookup");
    sweep_ob("R9 ob3 after ob1 off");

    // R7: very large sizes, including the whole 64-bit space
    set_ob(2, 32'h3, 32'h8_0000, 32'h8000_0028);
    set_ob(4, 32'h42, 32'h0, 32'h8000_003F);
    sweep_ob("R7 large sizes");
    look_ob(64'hFFFF_FFFF_FFFF_FFF0, "R7 R8 full space wraps");

    // R11: extended words ignored by lookups
    for (int n = 1; n <= 4; n++) wr(ob_off(n) + 12'h4, 32'hFFFF_FFFF);
    sweep_ob("R11 ob extended ignored");
    rd(ob_off(2) + 12'h4, v); chk("R11 ob ext stored", {96'h0, v}, {96'h0, 32'hFFFF_FFFF});

    // Inbound side
    set_ib(0, 32'h9000, 32'h40, 32'h0000_000C);
    set_ib(1, 32'h1, 32'h48, 32'h0000_000B);
    set_ib(2, 32'h2, 32'h3F, 32'h0000_000F);
    sweep_ib("R6 ib disabled");
    wr(ib_off(0) + 12'h10, 32'h8000_000C); mi_a[0] = 32'h8000_000C;
    wr(ib_off(1) + 12'h10, 32'h8000_000B); mi_a[1] = 32'h8000_000B;
    wr(ib_off(2) + 12'h10, 32'h8000_000F); mi_a[2] = 32'h8000_000F;
    sweep_ib("R7 R8 R9 ib enabled");
    look_ib(64'h0004_0000, "R9 ib0 over ib2");
    wr(ib_off(0) + 12'h10, 32'h0000_000C); mi_a[0] = 32'h0000_000C;
    look_ib(64'h0004_0000, "R9 ib2 after ib0 off");
    for (int m = 0; m <= 2; m++) wr(ib_off(m) + 12'hC, 32'hABCD_EF01);
    sweep_ib("R11 ib extended ignored");
    rd(ib_off(1) + 12'hC, v); chk("R11 ib ext stored", {96'h0, v}, {96'h0, 32'hABCD_EF01});
    wr(12'hE20, 32'h0);
    sweep_ib("R3 timer has no effect");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule